// File: doc/BRIEF.md
# Scanline and Frame Timing Generator

This block derives video line and frame timing from the system clock and supports two television standards. The length of a line in clocks is not a whole number. A 20.12 fixed-point accumulator sets each line's length to the integer part of the carried residue plus a per-standard increment. The fractional part carries into the next line, so the average line length over many lines is exact.

Line strobes advance a line counter, which wraps at the frame total. A vertical-blank interrupt pulses when the counter reaches the blanking line, and a blanking status level stays high until the frame wraps. A field bit toggles at each frame end. A separate divider, free-running across frames, produces an audio-service strobe once every fixed number of lines. A standard-select input picks the timing, but it is only sampled at frame boundaries, so a frame never mixes two standards.

Top module: `scan_timing_gen`

## Requirements
- R1: During and right after reset, the line number, the field bit, the audio line count and the fractional residue are all 0. The 60 Hz standard is active, so the first line lasts floor(INC_A / 4096) clocks.
- R2: Each line lasts floor((residue + increment) / 4096) clocks, and the new residue is the low 12 bits of that sum. After N lines from reset at a fixed standard, the total is exactly floor(N * increment / 4096) clocks. The 60 Hz increment is 8791293 and the 50 Hz increment is 8864320.
- R3: `line_stb_o` is high for exactly one cycle, the last clock of each line. `line_num_o` advances by one in the following cycle and holds its value otherwise.
- R4: A frame has 263 lines at 60 Hz and 313 lines at 50 Hz. On the last clock of the last line, `frame_end_o` pulses for one cycle, and the line number then returns to 0.
- R5: `vbl_irq_o` is a one-cycle pulse in the first cycle in which the line number equals 240.
- R6: `vblank_o` is high for every cycle in which the line number is 240 or greater, and low otherwise.
- R7: `field_o` is the low bit of the completed-frame count. It inverts in the cycle after each `frame_end_o`.
- R8: `audio_stb_o` pulses for one cycle, in the cycle after every 32nd line strobe. Its line count runs on across frame boundaries.
- R9: `std_sel_i` (0 = 60 Hz, 1 = 50 Hz) is sampled only on the clock that ends a frame. A change in the middle of a frame has no effect on that frame's line count or line lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| std_sel_i | input | 1 | Standard select: 0 = 60 Hz, 1 = 50 Hz |
| line_stb_o | output | 1 | Last clock of each line |
| vbl_irq_o | output | 1 | One-cycle vertical-blank interrupt |
| vblank_o | output | 1 | Blanking status level |
| frame_end_o | output | 1 | Last clock of each frame |
| field_o | output | 1 | Interlace field bit |
| line_num_o | output | LINE_W | Current line number |
| audio_stb_o | output | 1 | Audio-service strobe |

## Verification
On every cycle, the assertions check the following: the residue and increment are frozen between line ends, the line number moves only on a strobe, the interrupt lines up with the blanking line, the field toggles with line reset at frame end, the standard stays latched mid-frame, and the audio strobe follows a line strobe. Only the bench scenarios can show the exact line lengths and the long-run clock total. They also show the frame totals after a mid-frame standard change, and the audio period across frame boundaries. The bench runs a scaled configuration with short lines and frames, and it compares every output on every cycle against an arithmetic model.

// File: rtl/tg_pkg.sv
package tg_pkg;
  typedef enum logic {STD_60 = 1'b0, STD_50 = 1'b1} tv_std_e;
endpackage

// File: rtl/tg_line_timer.sv
module tg_line_timer #(
  parameter int unsigned ACC_W    = 32,
  parameter int unsigned FRAC_W   = 12,
  parameter int unsigned INIT_INC = 8791293
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] inc_nxt_i,
  output logic             stb_o
);
  localparam int unsigned LEN_W = ACC_W - FRAC_W;

  logic [FRAC_W-1:0] res_q;
  logic [ACC_W-1:0]  inc_q, sum;
  logic [LEN_W-1:0]  cnt_q, len;

  assign sum   = ACC_W'(res_q) + inc_q;
  assign len   = sum[ACC_W-1:FRAC_W];
  assign stb_o = (cnt_q == len - LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      res_q <= '0;
      inc_q <= ACC_W'(INIT_INC);
    end else if (stb_o) begin
      cnt_q <= '0;
      res_q <= sum[FRAC_W-1:0];
      inc_q <= inc_nxt_i;
    end else begin
      cnt_q <= cnt_q + LEN_W'(1);
    end
  end

  p_res_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_o |=> $stable(res_q) && $stable(inc_q));
  p_single_stb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> !stb_o);
endmodule

// File: rtl/tg_frame_seq.sv
module tg_frame_seq #(
  parameter int unsigned LINE_W   = 9,
  parameter int unsigned LINES_A  = 263,
  parameter int unsigned LINES_B  = 313,
  parameter int unsigned VBL_LINE = 240
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_stb_i,
  input  tg_pkg::tv_std_e   std_i,
  output logic [LINE_W-1:0] line_o,
  output logic              frame_end_o,
  output logic              vblank_o,
  output logic              vbl_irq_o,
  output logic              field_o,
  output tg_pkg::tv_std_e   std_o
);
  logic [LINE_W-1:0] line_q, tot;
  logic              field_q, irq_q;
  tg_pkg::tv_std_e   std_q;

  assign tot         = (std_q == tg_pkg::STD_50) ? LINE_W'(LINES_B) : LINE_W'(LINES_A);
  assign frame_end_o = line_stb_i && (line_q == tot - LINE_W'(1));
  assign vblank_o    = (line_q >= LINE_W'(VBL_LINE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= '0;
      field_q <= 1'b0;
      irq_q   <= 1'b0;
      std_q   <= tg_pkg::STD_60;
    end else begin
      irq_q <= line_stb_i && (line_q == LINE_W'(VBL_LINE - 1));
      if (frame_end_o) begin
        line_q  <= '0;
        field_q <= ~field_q;
        std_q   <= std_i;
      end else if (line_stb_i) begin
        line_q <= line_q + LINE_W'(1);
      end
    end
  end

  assign line_o    = line_q;
  assign vbl_irq_o = irq_q;
  assign field_o   = field_q;
  assign std_o     = std_q;

  p_line_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_stb_i |=> $stable(line_q));
  p_line_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_stb_i && !frame_end_o |=> line_q == $past(line_q) + LINE_W'(1));
  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> line_q == '0);
  p_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_q < tot);
  p_irq_line_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vbl_irq_o |-> line_q == LINE_W'(VBL_LINE) && $rose(vblank_o));
  p_field_flip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> field_q != $past(field_q));
  p_std_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_o |=> $stable(std_q));
endmodule

// File: rtl/tg_line_div.sv
module tg_line_div #(
  parameter int unsigned PERIOD = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic stb_o
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q;
  logic          stb_q, wrap;

  assign wrap = tick_i && (cnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= wrap;
      if (wrap)        cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + CW'(1);
    end
  end

  assign stb_o = stb_q;

  p_after_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |-> $past(tick_i));
endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen #(
  parameter int unsigned ACC_W     = 32,
  parameter int unsigned FRAC_W    = 12,
  parameter int unsigned INC_A     = 8791293,
  parameter int unsigned INC_B     = 8864320,
  parameter int unsigned LINES_A   = 263,
  parameter int unsigned LINES_B   = 313,
  parameter int unsigned VBL_LINE  = 240,
  parameter int unsigned AUD_LINES = 32,
  parameter int unsigned LINE_W    = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              std_sel_i,
  output logic              line_stb_o,
  output logic              vbl_irq_o,
  output logic              vblank_o,
  output logic              frame_end_o,
  output logic              field_o,
  output logic [LINE_W-1:0] line_num_o,
  output logic              audio_stb_o
);
  import tg_pkg::*;

  tv_std_e          std_q, std_nxt;
  logic [ACC_W-1:0] inc_nxt;

  assign std_nxt = frame_end_o ? tv_std_e'(std_sel_i) : std_q;
  assign inc_nxt = (std_nxt == STD_50) ? ACC_W'(INC_B) : ACC_W'(INC_A);

  tg_line_timer #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .INIT_INC(INC_A)) u_line (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_nxt_i(inc_nxt), .stb_o(line_stb_o)
  );

  tg_frame_seq #(.LINE_W(LINE_W), .LINES_A(LINES_A), .LINES_B(LINES_B),
                 .VBL_LINE(VBL_LINE)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_stb_i(line_stb_o),
    .std_i(tv_std_e'(std_sel_i)), .line_o(line_num_o), .frame_end_o(frame_end_o),
    .vblank_o(vblank_o), .vbl_irq_o(vbl_irq_o), .field_o(field_o), .std_o(std_q)
  );

  tg_line_div #(.PERIOD(AUD_LINES)) u_aud (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(line_stb_o), .stb_o(audio_stb_o)
  );
endmodule

// File: tb/scan_timing_gen_bench.sv
module scan_timing_gen_bench;
  localparam int INC_A = 21504;  // 5.25 clocks per line
  localparam int INC_B = 27307;  // ~6.667 clocks per line
  localparam int LA = 12, LB = 14, VBL = 9, AUD = 4, LW = 9;

  logic clk = 0, rst_n = 0, std_sel = 0;
  logic line_stb, vbl_irq, vblank, frame_end, field, audio_stb;
  logic [LW-1:0] line_num;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  scan_timing_gen #(.INC_A(INC_A), .INC_B(INC_B), .LINES_A(LA), .LINES_B(LB),
    .VBL_LINE(VBL), .AUD_LINES(AUD), .LINE_W(LW)) u_scan_timing_gen (
    .clk_i(clk), .rst_ni(rst_n), .std_sel_i(std_sel), .line_stb_o(line_stb),
    .vbl_irq_o(vbl_irq), .vblank_o(vblank), .frame_end_o(frame_end),
    .field_o(field), .line_num_o(line_num), .audio_stb_o(audio_stb));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // model state
  int m_res = 0, m_inc = INC_A, m_cnt = 0, m_line = 0, m_std = 0, m_field = 0;
  int m_aud = 0, m_irq = 0, m_audp = 0;
  int samples = 0, lines_done = 0, frame_lines = 0, lines_since_aud = -1;
  bit mid_change = 0;

  function automatic int inc_of(int s); return s ? INC_B : INC_A; endfunction
  function automatic int tot_of(int s); return s ? LB : LA; endfunction

  task automatic step();
    int len, e_stb, e_fe, sum;
    len   = (m_res + m_inc) >> 12;
    e_stb = (m_cnt == len - 1);
    e_fe  = e_stb && (m_line == tot_of(m_std) - 1);
    samples++;
    chk(line_stb == e_stb, "R3 line strobe / R2 length", line_stb, e_stb);
    chk(int'(line_num) == m_line, "R3 line number", line_num, m_line);
    chk(frame_end == e_fe, "R4 frame end", frame_end, e_fe);
    chk(vblank == (m_line >= VBL), "R6 vblank level", vblank, m_line >= VBL);
    chk(vbl_irq == m_irq, "R5 vblank irq", vbl_irq, m_irq);
    chk(field == m_field, "R7 field bit", field, m_field);
    chk(audio_stb == m_audp, "R8 audio strobe", audio_stb, m_audp);
    if (audio_stb) begin
      if (lines_since_aud >= 0)
        chk(lines_since_aud == AUD, "R8 audio period", lines_since_aud, AUD);
      lines_since_aud = 0;
    end
    if (line_stb) begin
      lines_done++;
      frame_lines++;
      if (lines_since_aud >= 0) lines_since_aud++;
      if (lines_done == LA && m_std == 0)
        chk(samples == (LA * INC_A) / 4096, "R2 long-run total", samples, (LA * INC_A) / 4096);
      if (lines_done == 3 * LA)
        chk(samples == (3 * LA * INC_A) / 4096, "R2 long-run total", samples, (3 * LA * INC_A) / 4096);
    end
    if (frame_end) begin
      if (mid_change)
        chk(frame_lines == tot_of(m_std), "R9 frame lines", frame_lines, tot_of(m_std));
      else
        chk(frame_lines == tot_of(m_std), "R4 frame lines", frame_lines, tot_of(m_std));
      frame_lines = 0;
      mid_change = 0;
    end
    // advance model through the coming edge
    m_irq  = e_stb && (m_line == VBL - 1);
    m_audp = e_stb && (m_aud == AUD - 1);
    if (e_stb) begin
      sum   = m_res + m_inc;
      m_res = sum & 4095;
      m_cnt = 0;
      m_aud = (m_aud == AUD - 1) ? 0 : m_aud + 1;
      if (e_fe) begin
        m_line  = 0;
        m_field ^= 1;
        m_std   = std_sel;
      end else m_line++;
      m_inc = inc_of(m_std);
    end else m_cnt++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      step();
      @(negedge clk);
    end
  endtask

  task automatic set_std(input bit v);
    if (v != std_sel) mid_change = 1;
    std_sel = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(line_num == 0, "R1 reset line", line_num, 0);
    chk(field == 0, "R1 reset field", field, 0);
    chk(!line_stb && !vbl_irq && !frame_end && !audio_stb && !vblank,
        "R1 reset pulses", line_stb, 0);
    rst_n = 1;
    run(400);            // 60 Hz frames
    set_std(1);          // mid-frame change
    run(37);
    set_std(1);
    run(500);            // 50 Hz frames
    set_std(0);
    run(20);
    set_std(1);          // brief glitch inside a frame
    run(3);
    set_std(0);
    run(400);
    set_std(1);
    run(200);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", samples, 1560);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule